// File: doc/BRIEF.md
# Stereo Logarithmic Volume Attenuator

This block scales two independent streams of signed 16-bit stereo audio, a music stream and a wave stream. Each stream has its own left and right attenuation. The four 8-bit codes sit in one 32-bit volume register that the host loads through a simple write strobe. A code gives the attenuation in decibels as a 6.2 fixed-point number, so one step is a quarter of a decibel. Code 00h passes the sample through unchanged and code FFh silences it.

The attenuation is built from two parts. The code is split into an octave count, code / 24, and a step within that octave, code mod 24. The step selects a fractional gain from a 24-entry table. The octave count becomes an arithmetic right shift. The product is rounded toward zero.

Each stream accepts a left/right pair in a single valid/ready beat and returns the scaled pair one cycle later from an output register, which respects backpressure. Both codes used for a pair are taken from the register in the cycle the pair is accepted. A write to the register therefore never splits a pair between old and new settings, and it never alters a result that is already held at the output.

Top module: `stereo_vol_atten`

## Requirements
- R1: A cycle with `reg_we` high loads `reg_wdata` into the volume register. Bits 7:0 are the wave left code, 15:8 the wave right code, 23:16 the music left code and 31:24 the music right code.
- R2: A code of 00h gives an output sample that is exactly equal to the input sample.
- R3: A code of FFh gives an output sample of exactly zero, whatever the input.
- R4: For any other code c, the output is the input times round(32768·10^(−(c mod 24)/80))/32768 times 2^−(c/24), rounded toward zero. The result lies within 2 LSB of the ideal value x·10^(−(c mod 24)/80)·2^−(c/24), its magnitude never exceeds the input magnitude, and it never has the opposite sign to the input.
- R5: A code of 24·n gives exactly x/2^n rounded toward zero, for negative inputs as well as positive ones (for example −3 becomes −1 at code 18h).
- R6: After reset the register holds 00008080h, so music passes at 0 dB and wave is attenuated by 32 dB (code 80h). After reset both output valids are low and both input readies are high.
- R7: A pair accepted at a rising edge (`*_in_valid` and `*_in_ready` both high) appears with `*_out_valid` high after that same edge. `*_out_valid` stays low when no pair is accepted and the output is empty or being taken.
- R8: While `*_out_valid` is high and `*_out_ready` is low, the output pair stays stable, `*_in_ready` is low, and no offered pair is lost. When the output is taken, a waiting pair is accepted in the same cycle.
- R9: The codes applied to a pair are the register contents in the cycle the pair is accepted. A write during a stall does not change the held result. A write in the same cycle as an acceptance affects only later pairs.
- R10: The music and wave streams are independent, so a stall on one does not hold up the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Volume register write strobe |
| reg_wdata | input | 32 | Volume register write data |
| mus_in_valid | input | 1 | Music input pair valid |
| mus_in_ready | output | 1 | Music input pair ready |
| mus_in_l | input | 16 | Music left input sample, signed |
| mus_in_r | input | 16 | Music right input sample, signed |
| mus_out_valid | output | 1 | Music output pair valid |
| mus_out_ready | input | 1 | Music output pair ready |
| mus_out_l | output | 16 | Music left output sample, signed |
| mus_out_r | output | 16 | Music right output sample, signed |
| wav_in_valid | input | 1 | Wave input pair valid |
| wav_in_ready | output | 1 | Wave input pair ready |
| wav_in_l | input | 16 | Wave left input sample, signed |
| wav_in_r | input | 16 | Wave right input sample, signed |
| wav_out_valid | output | 1 | Wave output pair valid |
| wav_out_ready | input | 1 | Wave output pair ready |
| wav_out_l | output | 16 | Wave left output sample, signed |
| wav_out_r | output | 16 | Wave right output sample, signed |

## Verification
The hardest case to reach from the ports is a register write that coincides with a pair held by the attenuator. One way is a write landing while the output register is stalled. The other is a write landing in the very cycle a pair is accepted.

The stimulus reaches the first case by pulling the music `out_ready` low and offering a second pair behind the held one. It then rewrites the codes to mute and releases the stall. The held pair must still carry the old gains, and the waiting pair must carry the new ones. For the second case, the bench raises the write strobe and the input valid on the same clock edge, then checks that the old codes were applied. While music is stalled, a wave pair is sent to show that the two streams do not block each other.

// File: rtl/vol_atten_pkg.sv
package vol_atten_pkg;

    localparam int CODE_W        = 8;
    localparam int STEPS_PER_OCT = 24;
    localparam int GAIN_FRAC     = 15;
    localparam int GAIN_W        = GAIN_FRAC + 1;
    localparam int SHIFT_W       = 5;
    localparam logic [CODE_W-1:0] MUTE_CODE = '1;

    // Register image: the field order fixes the bit positions.
    typedef struct packed {
        logic [CODE_W-1:0] mus_r;
        logic [CODE_W-1:0] mus_l;
        logic [CODE_W-1:0] wav_r;
        logic [CODE_W-1:0] wav_l;
    } vol_reg_t;

    localparam vol_reg_t VOL_RESET = 32'h0000_8080;

    typedef struct packed {
        logic               mute;
        logic [SHIFT_W-1:0] shift;
        logic [GAIN_W-1:0]  gain;
    } gain_t;

    // round(32768 * 10^(-k/80)) for the quarter-dB steps of one octave
    function automatic logic [GAIN_W-1:0] octave_frac(input logic [4:0] k);
        logic [GAIN_W-1:0] g;
        case (k)
            5'd0:    g = 16'd32768;
            5'd1:    g = 16'd31838;
            5'd2:    g = 16'd30935;
            5'd3:    g = 16'd30057;
            5'd4:    g = 16'd29205;
            5'd5:    g = 16'd28376;
            5'd6:    g = 16'd27571;
            5'd7:    g = 16'd26789;
            5'd8:    g = 16'd26029;
            5'd9:    g = 16'd25290;
            5'd10:   g = 16'd24573;
            5'd11:   g = 16'd23876;
            5'd12:   g = 16'd23198;
            5'd13:   g = 16'd22540;
            5'd14:   g = 16'd21900;
            5'd15:   g = 16'd21279;
            5'd16:   g = 16'd20675;
            5'd17:   g = 16'd20089;
            5'd18:   g = 16'd19519;
            5'd19:   g = 16'd18965;
            5'd20:   g = 16'd18427;
            5'd21:   g = 16'd17904;
            5'd22:   g = 16'd17396;
            5'd23:   g = 16'd16902;
            default: g = 16'd32768;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/vol_gain_lut.sv
module vol_gain_lut
    import vol_atten_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output gain_t             gain
);

    localparam logic [CODE_W-1:0] STEP_DIV = CODE_W'(STEPS_PER_OCT);

    logic [CODE_W-1:0] octave;
    logic [CODE_W-1:0] step;

    always_comb begin
        octave     = code / STEP_DIV;
        step       = code % STEP_DIV;
        gain.mute  = (code == MUTE_CODE);
        gain.shift = SHIFT_W'(GAIN_FRAC) + SHIFT_W'(octave);
        gain.gain  = octave_frac(5'(step));
    end

endmodule

// File: rtl/vol_scaler.sv
module vol_scaler
    import vol_atten_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic signed [SAMPLE_W-1:0] sample,
    input  gain_t                      gain,
    output logic signed [SAMPLE_W-1:0] result
);

    localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

    logic signed [PROD_W-1:0] prod;
    logic        [PROD_W-1:0] low_mask;
    logic signed [PROD_W-1:0] bias;

    always_comb begin
        prod     = $signed({{(PROD_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample})
                 * $signed({{(PROD_W-GAIN_W){1'b0}}, gain.gain});
        low_mask = ~({PROD_W{1'b1}} << gain.shift);
        // a negative product is biased up so the shift rounds toward zero
        bias     = prod[PROD_W-1] ? $signed(low_mask) : '0;
        result   = gain.mute ? '0 : SAMPLE_W'((prod + bias) >>> gain.shift);
    end

endmodule

// File: rtl/vol_stream.sv
module vol_stream
    import vol_atten_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CODE_W-1:0]          code_l,
    input  logic [CODE_W-1:0]          code_r,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic signed [SAMPLE_W-1:0] in_l,
    input  logic signed [SAMPLE_W-1:0] in_r,
    output logic                       out_valid,
    input  logic                       out_ready,
    output logic signed [SAMPLE_W-1:0] out_l,
    output logic signed [SAMPLE_W-1:0] out_r
);

    localparam int LANES = 2;

    typedef struct packed {
        logic                       valid;
        logic signed [SAMPLE_W-1:0] l;
        logic signed [SAMPLE_W-1:0] r;
    } out_reg_t;

    out_reg_t st_d, st_q;

    logic [LANES-1:0][CODE_W-1:0]   lane_code;
    logic [LANES-1:0][SAMPLE_W-1:0] lane_in;
    logic [LANES-1:0][SAMPLE_W-1:0] lane_out;

    assign lane_code = {code_r, code_l};
    assign lane_in   = {in_r, in_l};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        gain_t lane_gain;

        vol_gain_lut u_lut (
            .code (lane_code[i]),
            .gain (lane_gain)
        );

        vol_scaler #(.SAMPLE_W(SAMPLE_W)) u_scale (
            .sample ($signed(lane_in[i])),
            .gain   (lane_gain),
            .result (lane_out[i])
        );
    end

    assign in_ready = !st_q.valid || out_ready;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
        end
        if (in_valid && in_ready) begin
            st_d.valid = 1'b1;
            st_d.l     = $signed(lane_out[0]);
            st_d.r     = $signed(lane_out[1]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_l     = st_q.l;
    assign out_r     = st_q.r;

endmodule

// File: rtl/stereo_vol_atten.sv
module stereo_vol_atten
    import vol_atten_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [31:0]                reg_wdata,
    input  logic                       mus_in_valid,
    output logic                       mus_in_ready,
    input  logic signed [SAMPLE_W-1:0] mus_in_l,
    input  logic signed [SAMPLE_W-1:0] mus_in_r,
    output logic                       mus_out_valid,
    input  logic                       mus_out_ready,
    output logic signed [SAMPLE_W-1:0] mus_out_l,
    output logic signed [SAMPLE_W-1:0] mus_out_r,
    input  logic                       wav_in_valid,
    output logic                       wav_in_ready,
    input  logic signed [SAMPLE_W-1:0] wav_in_l,
    input  logic signed [SAMPLE_W-1:0] wav_in_r,
    output logic                       wav_out_valid,
    input  logic                       wav_out_ready,
    output logic signed [SAMPLE_W-1:0] wav_out_l,
    output logic signed [SAMPLE_W-1:0] wav_out_r
);

    vol_reg_t vol_d, vol_q;

    always_comb begin
        vol_d = vol_q;
        if (reg_we) begin
            vol_d = vol_reg_t'(reg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vol_q <= VOL_RESET;
        end else begin
            vol_q <= vol_d;
        end
    end

    vol_stream #(.SAMPLE_W(SAMPLE_W)) u_music (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_l    (vol_q.mus_l),
        .code_r    (vol_q.mus_r),
        .in_valid  (mus_in_valid),
        .in_ready  (mus_in_ready),
        .in_l      (mus_in_l),
        .in_r      (mus_in_r),
        .out_valid (mus_out_valid),
        .out_ready (mus_out_ready),
        .out_l     (mus_out_l),
        .out_r     (mus_out_r)
    );

    vol_stream #(.SAMPLE_W(SAMPLE_W)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .code_l    (vol_q.wav_l),
        .code_r    (vol_q.wav_r),
        .in_valid  (wav_in_valid),
        .in_ready  (wav_in_ready),
        .in_l      (wav_in_l),
        .in_r      (wav_in_r),
        .out_valid (wav_out_valid),
        .out_ready (wav_out_ready),
        .out_l     (wav_out_l),
        .out_r     (wav_out_r)
    );

endmodule

// File: rtl/vol_atten_chk.sv
module vol_atten_chk #(
    parameter int SAMPLE_W = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [31:0]                vol,
    input logic                       mus_in_valid,
    input logic                       mus_in_ready,
    input logic signed [SAMPLE_W-1:0] mus_in_l,
    input logic                       mus_out_valid,
    input logic                       mus_out_ready,
    input logic signed [SAMPLE_W-1:0] mus_out_l,
    input logic signed [SAMPLE_W-1:0] mus_out_r,
    input logic                       wav_in_valid,
    input logic                       wav_in_ready,
    input logic signed [SAMPLE_W-1:0] wav_in_l,
    input logic                       wav_out_valid,
    input logic                       wav_out_ready,
    input logic signed [SAMPLE_W-1:0] wav_out_l,
    input logic signed [SAMPLE_W-1:0] wav_out_r
);

    logic mus_take, wav_take;
    assign mus_take = mus_in_valid && mus_in_ready;
    assign wav_take = wav_in_valid && wav_in_ready;

    p_mus_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mus_take |=> mus_out_valid);
    p_wav_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wav_take |=> wav_out_valid);
    p_mus_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mus_take && (!mus_out_valid || mus_out_ready)) |=> !mus_out_valid);

    p_mus_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mus_out_valid && !mus_out_ready) |=>
            (mus_out_valid && $stable(mus_out_l) && $stable(mus_out_r)));
    p_wav_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wav_out_valid && !wav_out_ready) |=>
            (wav_out_valid && $stable(wav_out_l) && $stable(wav_out_r)));
    p_mus_empty_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mus_out_valid |-> mus_in_ready);

    p_mus_mute_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mus_take && vol[23:16] == 8'hFF) |=> (mus_out_l == '0));
    p_wav_mute_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wav_take && vol[7:0] == 8'hFF) |=> (wav_out_l == '0));

    p_mus_unity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mus_take && vol[23:16] == 8'h00) |=> (mus_out_l == $past(mus_in_l)));
    p_wav_unity_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wav_take && vol[7:0] == 8'h00) |=> (wav_out_l == $past(wav_in_l)));

endmodule

bind stereo_vol_atten vol_atten_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .vol           (vol_q),
    .mus_in_valid  (mus_in_valid),
    .mus_in_ready  (mus_in_ready),
    .mus_in_l      (mus_in_l),
    .mus_out_valid (mus_out_valid),
    .mus_out_ready (mus_out_ready),
    .mus_out_l     (mus_out_l),
    .mus_out_r     (mus_out_r),
    .wav_in_valid  (wav_in_valid),
    .wav_in_ready  (wav_in_ready),
    .wav_in_l      (wav_in_l),
    .wav_out_valid (wav_out_valid),
    .wav_out_ready (wav_out_ready),
    .wav_out_l     (wav_out_l),
    .wav_out_r     (wav_out_r)
);

// File: tb/stereo_vol_atten_tb_top.sv
module stereo_vol_atten_tb_top;

    localparam int SW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic mus_in_valid = 1'b0, mus_in_ready, mus_out_valid, mus_out_ready = 1'b1;
    logic wav_in_valid = 1'b0, wav_in_ready, wav_out_valid, wav_out_ready = 1'b1;
    logic signed [SW-1:0] mus_in_l = '0, mus_in_r = '0, mus_out_l, mus_out_r;
    logic signed [SW-1:0] wav_in_l = '0, wav_in_r = '0, wav_out_l, wav_out_r;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    stereo_vol_atten #(.SAMPLE_W(SW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .mus_in_valid(mus_in_valid), .mus_in_ready(mus_in_ready),
        .mus_in_l(mus_in_l), .mus_in_r(mus_in_r),
        .mus_out_valid(mus_out_valid), .mus_out_ready(mus_out_ready),
        .mus_out_l(mus_out_l), .mus_out_r(mus_out_r),
        .wav_in_valid(wav_in_valid), .wav_in_ready(wav_in_ready),
        .wav_in_l(wav_in_l), .wav_in_r(wav_in_r),
        .wav_out_valid(wav_out_valid), .wav_out_ready(wav_out_ready),
        .wav_out_l(wav_out_l), .wav_out_r(wav_out_r)
    );

    // {register value, left sample, right sample}; both streams get the same samples
    localparam logic [63:0] VEC [8] = '{
        {32'h0000_0000, 16'sd12345,  -16'sd12345},
        {32'hFFFF_FFFF, 16'sd32767,  -16'sd32768},
        {32'h0102_0304, 16'sd20000,  -16'sd20000},
        {32'h1830_0C17, -16'sd32768, 16'sd32767},
        {32'hFEFE_FEFE, 16'sd32767,  -16'sd32767},
        {32'h7F81_40BF, 16'sd1,      -16'sd1},
        {32'h05A0_3B11, -16'sd25000, 16'sd18000},
        {32'h00FF_FF00, -16'sd5,     16'sd5}
    };

    task automatic check_eq(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Gain model taken from the requirements: exact for 00h and FFh, otherwise
    // within 2 LSB of the ideal, never larger, never of opposite sign.
    task automatic check_lane(input string req, input int x, input int code, input int y);
        real ideal;
        bit  ok;
        n_tests++;
        if (code == 0) begin
            ideal = real'(x);
            ok = (y == x);
        end else if (code == 255) begin
            ideal = 0.0;
            ok = (y == 0);
        end else begin
            ideal = real'(x) * $pow(10.0, -real'(code % 24) / 80.0)
                  * $pow(2.0, -real'(code / 24));
            ok = ((real'(y) - ideal) < 2.0) && ((ideal - real'(y)) < 2.0);
            if (x >= 0) ok = ok && (y >= 0) && (y <= x);
            else        ok = ok && (y <= 0) && (y >= x);
        end
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: code %0h input %0d actual %0d expected %0.2f",
                     req, code, x, y, ideal);
        end
    endtask

    task automatic write_reg(input logic [31:0] v);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    // offer a pair on both streams for one edge; returns at the next negedge
    task automatic send_both(input logic signed [SW-1:0] l, input logic signed [SW-1:0] r);
        @(negedge clk);
        mus_in_valid = 1'b1; mus_in_l = l; mus_in_r = r;
        wav_in_valid = 1'b1; wav_in_l = l; wav_in_r = r;
        @(negedge clk);
        mus_in_valid = 1'b0;
        wav_in_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset state at the ports
        check_eq("R6 mus_out_valid in reset", int'(mus_out_valid), 0);
        check_eq("R6 wav_out_valid in reset", int'(wav_out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R6 mus_in_ready after reset", int'(mus_in_ready), 1);
        check_eq("R6 wav_in_ready after reset", int'(wav_in_ready), 1);

        // R6: default codes, music 0 dB and wave code 80h
        send_both(16'sd32767, -16'sd1000);
        check_eq("R6 R7 mus_out_valid", int'(mus_out_valid), 1);
        check_lane("R6 music left default", 32767, 0, int'(mus_out_l));
        check_lane("R6 music right default", -1000, 0, int'(mus_out_r));
        check_lane("R6 wave left default", 32767, 8'h80, int'(wav_out_l));
        check_lane("R6 wave right default", -1000, 8'h80, int'(wav_out_r));
        @(negedge clk);
        check_eq("R7 mus_out_valid idle", int'(mus_out_valid), 0);

        // R1 R2 R3 R4: vector table
        for (int i = 0; i < 8; i++) begin
            logic [31:0] v;
            int l, r;
            v = VEC[i][63:32];
            l = int'($signed(VEC[i][31:16]));
            r = int'($signed(VEC[i][15:0]));
            write_reg(v);
            send_both(SW'(l), SW'(r));
            check_lane("R1 R4 wave left [7:0]",    l, int'(v[7:0]),   int'(wav_out_l));
            check_lane("R1 R4 wave right [15:8]",  r, int'(v[15:8]),  int'(wav_out_r));
            check_lane("R1 R4 music left [23:16]", l, int'(v[23:16]), int'(mus_out_l));
            check_lane("R1 R4 music right [31:24]", r, int'(v[31:24]), int'(mus_out_r));
        end

        // R5: exact halving per 24 steps, truncation toward zero
        write_reg(32'h3018_1800);
        send_both(-16'sd3, -16'sd32768);
        check_eq("R5 music left code 18h of -3", int'(mus_out_l), -1);
        check_eq("R5 music right code 30h of -32768", int'(mus_out_r), -8192);
        check_eq("R5 wave right code 18h of -32768", int'(wav_out_r), -16384);
        send_both(16'sd32767, 16'sd7);
        check_eq("R5 music left code 18h of 32767", int'(mus_out_l), 16383);
        check_eq("R5 music right code 30h of 7", int'(mus_out_r), 1);

        // R8 R9 R10: stall music, rewrite codes during the stall
        write_reg(32'h0C00_0000);
        @(negedge clk);
        mus_out_ready = 1'b0;
        mus_in_valid = 1'b1; mus_in_l = 16'sd1000; mus_in_r = 16'sd1000;
        @(negedge clk);
        mus_in_l = 16'sd2000; mus_in_r = 16'sd2000;     // second pair waits
        check_eq("R8 mus_in_ready low while stalled", int'(mus_in_ready), 0);
        reg_we = 1'b1; reg_wdata = 32'hFFFF_0000;
        wav_in_valid = 1'b1; wav_in_l = -16'sd777; wav_in_r = 16'sd555;
        @(negedge clk);
        reg_we = 1'b0;
        wav_in_valid = 1'b0;
        check_eq("R10 wave flows during music stall", int'(wav_out_valid), 1);
        check_eq("R10 wave left", int'(wav_out_l), -777);
        check_eq("R10 wave right", int'(wav_out_r), 555);
        @(negedge clk);
        check_eq("R8 mus_out_valid held", int'(mus_out_valid), 1);
        check_eq("R9 held left keeps old code", int'(mus_out_l), 1000);
        check_lane("R9 held right keeps old code", 1000, 12, int'(mus_out_r));
        mus_out_ready = 1'b1;
        @(negedge clk);
        mus_in_valid = 1'b0;
        check_eq("R8 waiting pair accepted", int'(mus_out_valid), 1);
        check_eq("R9 new code left mutes", int'(mus_out_l), 0);
        check_eq("R9 new code right mutes", int'(mus_out_r), 0);

        // R9: write in the same cycle as an acceptance
        @(negedge clk);
        mus_in_valid = 1'b1; mus_in_l = 16'sd4000; mus_in_r = -16'sd4000;
        reg_we = 1'b1; reg_wdata = 32'h0000_0000;
        @(negedge clk);
        mus_in_valid = 1'b0; reg_we = 1'b0;
        check_eq("R9 same-cycle write left uses old", int'(mus_out_l), 0);
        check_eq("R9 same-cycle write right uses old", int'(mus_out_r), 0);
        send_both(16'sd4000, -16'sd4000);
        check_eq("R9 next pair left uses new", int'(mus_out_l), 4000);
        check_eq("R9 next pair right uses new", int'(mus_out_r), -4000);

        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule